// File: doc/BRIEF.md
# Self-Correcting Periodic Branch Predictor

This block predicts the outcome of one conditional branch whose behaviour repeats with a fixed period. A preloaded outcome pattern sits in a circular register. Every time the branch strobe fires, the register rotates by one place, so the predictor replays the pattern in order. The pattern length and its starting contents are parameters.

The actual outcome comes back with the strobe. If the very first prediction after reset turns out wrong, the block assumes it is being fed the complement of its pattern. In the same edge that rotates the register, it inverts every stored bit. From then on it follows the complemented sequence with no further errors.

A 2-bit saturating counter is updated by the same strobe and outcome. A select input chooses which of the two predictions drives the output, so one run can compare the two schemes on the same branch stream.

Top module: `periodic_branch_predictor`

## Requirements
- R1: After reset the pattern register holds PAT_INIT and the pattern prediction is PAT_INIT[PAT_LEN-1]. The counter holds 1 (weakly not taken), so the counter prediction is 0.
- R2: The pattern prediction is the most significant bit of the pattern register. Each strobed branch rotates the register left by one place, with bit PAT_LEN-1 wrapping into bit 0. The rotated value sets the prediction from the cycle after the strobe edge.
- R3: In a cycle with `br_valid` low, neither the pattern register nor the counter changes, whatever `br_taken` does.
- R4: On the first strobed branch after reset, if the pattern prediction differs from `br_taken`, the rotated pattern is also bit-wise inverted in the same edge.
- R5: Only the first strobed branch after reset can invert the pattern. Later mispredictions only rotate it.
- R6: If the outcome stream replays the pattern from reset, every pattern prediction is correct. If it replays the exact complement, only the first prediction is wrong.
- R7: The counter increments on a taken outcome, saturating at 3, and decrements on a not-taken outcome, saturating at 0. It predicts taken for the values 2 and 3.
- R8: With `pred_src` = 0 the output shows the pattern prediction, and with 1 it shows the counter prediction. The output follows a change of `pred_src` in the same cycle. Both predictors update on every strobe in either setting.
- R9: With PAT_LEN = 5 and PAT_INIT = 5'b11100, the predictor yields taken, taken, taken, not taken, not taken, repeating.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| br_valid | input | 1 | Strobe: a conditional branch resolves this cycle |
| br_taken | input | 1 | Actual outcome of the strobed branch, 1 = taken |
| pred_src | input | 1 | Output select: 0 = pattern predictor, 1 = saturating counter |
| pred_taken | output | 1 | Prediction for the next branch, 1 = taken |

## Verification
The prediction comes straight from registers. A strobe applied before rising edge n is therefore reflected in `pred_taken` only after edge n, and a change of `pred_src` shows up within the same cycle. The bench drives every branch after a falling edge. It samples the output for both select settings a few nanoseconds before the rising edge that consumes the strobe, so each sample sees the state left by the previous branch. It sweeps every 6-outcome sequence after reset on a 4-entry and a 5-entry instance, plus long replays of each pattern and its complement. Expected predictions are computed from the pattern index modulo its length and a flip bit fixed by the first outcome.

// File: rtl/bp_pkg.sv
package bp_pkg;

  // Which predictor drives the output.
  typedef enum logic {
    SRC_PATTERN = 1'b0,
    SRC_COUNTER = 1'b1
  } pred_src_e;

endpackage

// File: rtl/bpp_arm.sv
// Tracks whether the one-shot pattern inversion is still available.
// Set at reset and consumed by the first strobed branch.
module bpp_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  output logic armed
);

  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    armed_q <= 1'b1;
    else if (step) armed_q <= 1'b0;
  end

  assign armed = armed_q;

  // Once consumed, the arm never comes back until reset.
  p_arm_never_rearms_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |=> !armed_q);

endmodule

// File: rtl/bpp_ring.sv
// Circular outcome pattern: rotates left on each step and optionally
// complements the whole rotated value.
module bpp_ring #(
  parameter int                 LEN  = 4,
  parameter logic [LEN-1:0]     INIT = 4'b1101
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic invert,
  output logic pred
);

  logic [LEN-1:0] pat_q;
  logic [LEN-1:0] rotated;
  logic [LEN-1:0] pat_d;

  // Top bit wraps into the bottom.
  assign rotated = {pat_q[LEN-2:0], pat_q[LEN-1]};

  always_comb begin
    pat_d = pat_q;
    if (step) pat_d = invert ? ~rotated : rotated;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pat_q <= INIT;
    else        pat_q <= pat_d;
  end

  assign pred = pat_q[LEN-1];

  // Idle cycles leave the pattern untouched.
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(pat_q));

  // Plain rotation keeps the number of taken entries.
  p_rotate_keeps_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step && !invert |=> $countones(pat_q) == $countones($past(pat_q)));

  // Inversion turns every entry over.
  p_invert_flips_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step && invert |=> $countones(pat_q) == LEN - $countones($past(pat_q)));

endmodule

// File: rtl/bpp_satcnt.sv
// Conventional saturating up/down counter predictor.
module bpp_satcnt #(
  parameter int W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic taken,
  output logic pred
);

  localparam logic [W-1:0] CMAX  = {W{1'b1}};
  localparam logic [W-1:0] CMIN  = '0;
  localparam logic [W-1:0] CWEAK = {1'b0, {(W-1){1'b1}}};

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (step) begin
      if (taken  && cnt_q != CMAX) cnt_d = cnt_q + 1'b1;
      if (!taken && cnt_q != CMIN) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CWEAK;
    else        cnt_q <= cnt_d;
  end

  // Upper half of the range predicts taken.
  assign pred = cnt_q[W-1];

  p_cnt_sat_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    step && taken && cnt_q == CMAX |=> cnt_q == CMAX);

  p_cnt_sat_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    step && !taken && cnt_q == CMIN |=> cnt_q == CMIN);

  p_cnt_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(cnt_q));

endmodule

// File: rtl/periodic_branch_predictor.sv
module periodic_branch_predictor
  import bp_pkg::*;
#(
  parameter int                 PAT_LEN  = 4,
  parameter logic [PAT_LEN-1:0] PAT_INIT = 4'b1101,
  parameter int                 CNT_W    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic br_valid,
  input  logic br_taken,
  input  logic pred_src,
  output logic pred_taken
);

  logic      ring_pred;
  logic      cnt_pred;
  logic      armed;
  logic      flip_now;
  pred_src_e src;

  // Inversion only on the first strobe, and only when the pattern missed.
  assign flip_now = br_valid & armed & (ring_pred != br_taken);

  bpp_arm u_arm (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (br_valid),
    .armed (armed)
  );

  bpp_ring #(
    .LEN  (PAT_LEN),
    .INIT (PAT_INIT)
  ) u_ring (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (br_valid),
    .invert (flip_now),
    .pred   (ring_pred)
  );

  bpp_satcnt #(
    .W (CNT_W)
  ) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (br_valid),
    .taken (br_taken),
    .pred  (cnt_pred)
  );

  assign src = pred_src_e'(pred_src);

  always_comb begin
    case (src)
      SRC_COUNTER: pred_taken = cnt_pred;
      default:     pred_taken = ring_pred;
    endcase
  end

  // Any strobe consumes the one-shot inversion.
  p_arm_consumed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid |=> !armed);

  // No strobe and no select change: the output holds.
  p_idle_output_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !br_valid && $stable(pred_src) |=> $stable(pred_taken) || $changed(pred_src));

endmodule

// File: tb/periodic_branch_predictor_test.sv
module periodic_branch_predictor_test;

  localparam logic [7:0] INIT4 = 8'b0000_1101;
  localparam logic [7:0] INIT5 = 8'b0001_1100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 1'b0;
  logic tkn = 1'b0;
  logic sel = 1'b0;
  logic pred4;
  logic pred5;

  always #4 clk = ~clk;

  periodic_branch_predictor #(.PAT_LEN(4), .PAT_INIT(4'b1101), .CNT_W(2)) uut (
    .clk(clk), .rst_n(rst_n), .br_valid(vld), .br_taken(tkn),
    .pred_src(sel), .pred_taken(pred4));

  periodic_branch_predictor #(.PAT_LEN(5), .PAT_INIT(5'b11100), .CNT_W(2)) uut5 (
    .clk(clk), .rst_n(rst_n), .br_valid(vld), .br_taken(tkn),
    .pred_src(sel), .pred_taken(pred5));

  int nchk = 0;
  int nfail = 0;
  int k = 0;
  bit flip4 = 0;
  bit flip5 = 0;
  int cnt = 1;
  int wrong4 = 0;
  int wrong5 = 0;

  task automatic check(input logic got, input logic exp, input string req, input string what);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s %s: got %0b expected %0b (branch %0d)", req, what, got, exp, k);
    end
  endtask

  function automatic logic exp_pat(input int len, input logic [7:0] init, input int idx, input bit fl);
    return init[len-1-(idx % len)] ^ fl;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; vld = 1'b0; sel = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    k = 0; flip4 = 0; flip5 = 0; cnt = 1; wrong4 = 0; wrong5 = 0;
    #1;
    check(pred4, 1'b1, "R1", "reset pattern prediction (4)");
    check(pred5, 1'b1, "R1", "reset pattern prediction (5)");
    sel = 1'b1; #1;
    check(pred4, 1'b0, "R1", "reset counter prediction");
    sel = 1'b0;
  endtask

  // One strobed branch: check both predictions, then apply the outcome.
  task automatic branch(input logic outcome, input string req);
    @(negedge clk);
    sel = 1'b0; #1;
    check(pred4, exp_pat(4, INIT4, k, flip4), req, "pattern prediction (4) R2 R8");
    check(pred5, exp_pat(5, INIT5, k, flip5), req, "pattern prediction (5) R9");
    if (pred4 !== outcome) wrong4++;
    if (pred5 !== outcome) wrong5++;
    sel = 1'b1; #1;
    check(pred4, logic'(cnt >= 2), req, "counter prediction R7 R8");
    sel = 1'b0;
    vld = 1'b1; tkn = outcome;
    @(posedge clk);
    #1 vld = 1'b0;
    if (k == 0) begin
      flip4 = (INIT4[3] != outcome);
      flip5 = (INIT5[4] != outcome);
    end
    k++;
    if (outcome) cnt = (cnt < 3) ? cnt + 1 : 3;
    else         cnt = (cnt > 0) ? cnt - 1 : 0;
  endtask

  initial begin : watchdog
    #(8 * 150000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin : stim
    // Near-exhaustive: every 6-outcome sequence after reset (R4 R5 R7).
    for (int s = 0; s < 64; s++) begin
      do_reset();
      for (int i = 0; i < 6; i++) branch(s[i], "R4 R5 R7");
    end

    // R3: idle cycles with a toggling outcome leave every prediction alone.
    do_reset();
    branch(1'b0, "R4");
    branch(1'b1, "R5");
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      tkn = ~tkn;
    end
    branch(1'b1, "R3");
    branch(1'b0, "R3");

    // R6: replay of the 4-entry pattern.
    do_reset();
    for (int i = 0; i < 40; i++) branch(INIT4[3-(i % 4)], "R6");
    nchk++;
    if (wrong4 != 0) begin nfail++; $display("FAIL R6 replay misses: got %0d expected 0", wrong4); end

    // R6: complement of the 4-entry pattern.
    do_reset();
    for (int i = 0; i < 40; i++) branch(~INIT4[3-(i % 4)], "R6");
    nchk++;
    if (wrong4 != 1) begin nfail++; $display("FAIL R6 complement misses: got %0d expected 1", wrong4); end

    // R9: replay and complement of the 5-entry pattern.
    do_reset();
    for (int i = 0; i < 40; i++) branch(INIT5[4-(i % 5)], "R9");
    nchk++;
    if (wrong5 != 0) begin nfail++; $display("FAIL R9 replay misses: got %0d expected 0", wrong5); end
    do_reset();
    for (int i = 0; i < 40; i++) branch(~INIT5[4-(i % 5)], "R9");
    nchk++;
    if (wrong5 != 1) begin nfail++; $display("FAIL R9 complement misses: got %0d expected 1", wrong5); end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule